// File: doc/BRIEF.md
# Two-Channel Native DSD Bit Serializer

The block takes two 32-bit words at a time, one for the left channel and one for the right, each holding native 1-bit DSD audio. Every word is made of four bytes of eight DSD bits. The least significant byte plays first, and inside each byte the most significant bit plays first. The block shifts both channels out in lockstep on two data pins. It also produces a DSD bit clock that it divides down from the master clock, which also clocks the block.

A two-bit select sets the divide ratio to 1, 2, 4 or 8 master cycles per DSD bit. An optional shaping mode returns every '1' bit to low for the final master cycle of its bit period. New word pairs arrive over a valid/ready handshake with no gap between words. If no pair is offered at a word boundary, the block plays a silence word and raises an underrun flag. If a second boundary also passes with no word, the block stops and goes idle. The divide ratio and the shaping mode are taken only when streaming starts from idle.

Top module: `dsd_native_serializer`

## Requirements
- R1: While reset is asserted and while idle, `dsd_clk_o`, `dsd_l_o`, `dsd_r_o` and `underrun_o` are low and `word_ready_o` is high.
- R2: Output bit k of a word (k = 0..31) is word bit 8*(k/8) + 7 - (k mod 8). Both lanes use this order and play in lockstep, each from its own word.
- R3: `div_sel_i` values 0, 1, 2 and 3 select 1, 2, 4 and 8 master cycles per DSD bit. Each word lasts exactly 32 DSD bits.
- R4: For ratios 2, 4 and 8, the DSD clock is low for the first half of each bit period and high for the second half. Data changes only at the start of a bit period, which coincides with the falling edge of the DSD clock.
- R5: At ratio 1, while streaming, the DSD clock is the inverted master clock: low while the master clock is high and high while it is low.
- R6: `word_ready_o` is high while idle and during the last master cycle of each word. A pair is taken on a rising edge with valid and ready both high. Its first bit starts in the very next master cycle.
- R7: When `word_ready_o` is high during a word's last cycle but `word_valid_i` is low, the next word played on both lanes is the silence pattern 0x69 in every byte (per byte, in play order: 0,1,1,0,1,0,0,1). `underrun_o` stays high for exactly that word.
- R8: If the silence word ends with still no valid pair, the block returns to idle in the next cycle and shows the idle state of R1.
- R9: `div_sel_i` and `shape_en_i` are sampled only when a pair is taken from idle. Changes to them while streaming have no effect on the outputs.
- R10: With shaping enabled and a ratio of 2 or more, both data pins are low in the last master cycle of every bit period, for data and silence words alike. '0' bits stay low. At ratio 1 shaping has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_sel_i | input | 2 | Ratio select: 0→1, 1→2, 2→4, 3→8 |
| shape_en_i | input | 1 | Enables return-to-low shaping of '1' bits |
| word_valid_i | input | 1 | A word pair is offered |
| word_ready_o | output | 1 | The block takes a pair at the next rising edge |
| word_l_i | input | 32 | Left channel word |
| word_r_i | input | 32 | Right channel word |
| dsd_clk_o | output | 1 | DSD bit clock |
| dsd_l_o | output | 1 | Left DSD data |
| dsd_r_o | output | 1 | Right DSD data |
| underrun_o | output | 1 | High while a silence word is playing |

## Verification
A pair taken at a rising edge shows its first bit in the cycle that edge opens. Bit k, phase p is therefore due in master cycle k*ratio + p counted from that edge. The bench walks this index with its own loops and samples one nanosecond after each rising edge. The ready flag is expected only in phase ratio-1 of bit 31. The underrun flag is due from the first cycle of the silence word, and the idle state from the cycle after that word's last phase. At ratio 1 the clock's high phase is checked a second time one nanosecond after each falling edge.

// File: rtl/dsd_ser_pkg.sv
package dsd_ser_pkg;
  localparam int SER_W  = 32;
  localparam int BYTE_W = 8;
  localparam int NBYTES = SER_W / BYTE_W;
  localparam int CNT_W  = 3;
  localparam int IDX_W  = $clog2(SER_W);
  localparam logic [BYTE_W-1:0] IDLE_BYTE = 8'h69;
  localparam logic [SER_W-1:0]  IDLE_WORD = {NBYTES{IDLE_BYTE}};

  // Swap byte order, then mirror the whole word: LSB of result plays first.
  function automatic logic [SER_W-1:0] play_order(input logic [SER_W-1:0] w);
    logic [SER_W-1:0] swapped;
    logic [SER_W-1:0] mirrored;
    for (int b = 0; b < NBYTES; b++)
      swapped[b*BYTE_W +: BYTE_W] = w[(NBYTES-1-b)*BYTE_W +: BYTE_W];
    for (int i = 0; i < SER_W; i++)
      mirrored[i] = swapped[SER_W-1-i];
    return mirrored;
  endfunction

  // Last phase index of a bit period for a ratio select.
  function automatic logic [CNT_W-1:0] last_phase_of(input logic [1:0] sel);
    case (sel)
      2'd0:    return CNT_W'(0);
      2'd1:    return CNT_W'(1);
      2'd2:    return CNT_W'(3);
      default: return CNT_W'(7);
    endcase
  endfunction
endpackage

// File: rtl/dsd_phase_gen.sv
module dsd_phase_gen
  import dsd_ser_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             bypass_i,
  input  logic [CNT_W-1:0] last_phase_i,
  output logic [CNT_W-1:0] phase_o,
  output logic             bit_last_o,
  output logic             dsd_clk_o
);
  logic [CNT_W-1:0] phase_q;

  assign bit_last_o = run_i && (phase_q == last_phase_i);
  assign phase_o    = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    phase_q <= '0;
    else if (!run_i || bit_last_o)  phase_q <= '0;
    else                            phase_q <= phase_q + 1'b1;
  end

  // Low for the first half of the bit period, high for the second half.
  assign dsd_clk_o = run_i && (bypass_i ? !clk_i : (phase_q > (last_phase_i >> 1)));

  // R3: phase never passes the last phase of the selected ratio
  p_phase_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (phase_q <= last_phase_i));
  // R4: each divided bit period opens with the clock low
  p_clk_low_open_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !bypass_i && phase_q == '0) |-> !dsd_clk_o);
  // R4: the last phase of a divided period has the clock high
  p_clk_high_close_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_last_o && !bypass_i) |-> dsd_clk_o);
endmodule

// File: rtl/dsd_lane.sv
module dsd_lane
  import dsd_ser_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             shift_i,
  input  logic [SER_W-1:0] word_i,
  output logic             bit_o
);
  logic [SER_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (load_i)  sr_q <= play_order(word_i);
    else if (shift_i) sr_q <= sr_q >> 1;
  end

  assign bit_o = sr_q[0];

  // R2: the first bit played after a load is bit 7 of the loaded word
  p_first_bit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (bit_o == $past(word_i[BYTE_W-1])));
endmodule

// File: rtl/dsd_native_serializer.sv
module dsd_native_serializer
  import dsd_ser_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       div_sel_i,
  input  logic             shape_en_i,
  input  logic             word_valid_i,
  output logic             word_ready_o,
  input  logic [SER_W-1:0] word_l_i,
  input  logic [SER_W-1:0] word_r_i,
  output logic             dsd_clk_o,
  output logic             dsd_l_o,
  output logic             dsd_r_o,
  output logic             underrun_o
);
  localparam int NLANE = 2;

  logic             run_q, shape_q, uflow_q;
  logic [1:0]       sel_q;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] last_phase, phase;
  logic             bypass, bit_last, word_last, take, refill, lane_load, cut;
  logic [NLANE-1:0][SER_W-1:0] lane_word_in;
  logic [NLANE-1:0]            lane_bit;

  assign last_phase = last_phase_of(sel_q);
  assign bypass     = (sel_q == 2'd0);

  dsd_phase_gen u_phase (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_q), .bypass_i(bypass),
    .last_phase_i(last_phase), .phase_o(phase), .bit_last_o(bit_last),
    .dsd_clk_o(dsd_clk_o)
  );

  assign word_last    = bit_last && (idx_q == IDX_W'(SER_W-1));
  assign word_ready_o = !run_q || word_last;
  assign take         = word_valid_i && word_ready_o;
  assign refill       = word_last && !word_valid_i && !uflow_q;
  assign lane_load    = take || refill;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0; sel_q <= 2'd0; shape_q <= 1'b0; uflow_q <= 1'b0; idx_q <= '0;
    end else if (!run_q) begin
      idx_q   <= '0;
      uflow_q <= 1'b0;
      if (word_valid_i) begin
        run_q   <= 1'b1;
        sel_q   <= div_sel_i;
        shape_q <= shape_en_i;
      end
    end else if (word_last) begin
      idx_q <= '0;
      if (word_valid_i) uflow_q <= 1'b0;
      else if (uflow_q) begin
        run_q   <= 1'b0;
        uflow_q <= 1'b0;
      end else uflow_q <= 1'b1;
    end else if (bit_last) begin
      idx_q <= idx_q + 1'b1;
    end
  end

  assign lane_word_in[0] = take ? word_l_i : IDLE_WORD;
  assign lane_word_in[1] = take ? word_r_i : IDLE_WORD;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    dsd_lane u_lane (
      .clk_i(clk_i), .rst_ni(rst_ni), .load_i(lane_load), .shift_i(bit_last),
      .word_i(lane_word_in[g]), .bit_o(lane_bit[g])
    );
  end

  assign cut        = shape_q && !bypass && bit_last;
  assign dsd_l_o    = run_q && lane_bit[0] && !cut;
  assign dsd_r_o    = run_q && lane_bit[1] && !cut;
  assign underrun_o = uflow_q;

  // R1: the clock stays low while reset is held
  p_clk_reset_r1: assert property (@(posedge clk_i) !rst_ni |-> !dsd_clk_o);
  // R6: a pair offered at a boundary keeps the stream running without underrun
  p_no_gap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_last && word_valid_i) |=> (run_q && !underrun_o));
  // R7: a missed boundary starts a silence word flagged as underrun
  p_uflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_last && !word_valid_i && !uflow_q) |=> underrun_o);
  // R8: a second missed boundary returns to idle
  p_idle_back_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_last && !word_valid_i && uflow_q) |=> (!run_q && !dsd_clk_o && !underrun_o && word_ready_o));
  // R9: ratio and shaping hold while streaming
  p_cfg_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && $past(run_q)) |-> ($stable(sel_q) && $stable(shape_q)));
  // R10: shaped periods end low on both lanes
  p_shape_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_last && shape_q && !bypass) |-> (!dsd_l_o && !dsd_r_o));
endmodule

// File: tb/test_dsd_native_serializer.sv
`timescale 1ns/1ps
module test_dsd_native_serializer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  div_sel = 2'd0;
  logic        shape_en = 1'b0;
  logic        valid = 1'b0;
  logic        ready;
  logic [31:0] wl_in = '0, wr_in = '0;
  logic        dclk, dl, dr, uflow;

  int nchecks = 0;
  int nerr = 0;
  logic [31:0] wl [0:7];
  logic [31:0] wr [0:7];
  bit          hole [0:7];
  localparam logic [31:0] SILENCE = 32'h6969_6969;

  always #2.5 clk = ~clk;

  dsd_native_serializer i_dsd_native_serializer (
    .clk_i(clk), .rst_ni(rst_n), .div_sel_i(div_sel), .shape_en_i(shape_en),
    .word_valid_i(valid), .word_ready_o(ready), .word_l_i(wl_in), .word_r_i(wr_in),
    .dsd_clk_o(dclk), .dsd_l_o(dl), .dsd_r_o(dr), .underrun_o(uflow)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    nchecks++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Bit k of a word in play order: low byte first, MSB first within a byte.
  function automatic logic play_bit(input logic [31:0] w, input int k);
    return w[8*(k/8) + 7 - (k%8)];
  endfunction

  task automatic idle_checks(input int cycles);
    for (int c = 0; c < cycles; c++) begin
      @(posedge clk); #1;
      check("R1 R8 idle clock", dclk, 1'b0);
      check("R1 R8 idle left", dl, 1'b0);
      check("R1 R8 idle right", dr, 1'b0);
      check("R1 R8 idle underrun", uflow, 1'b0);
      check("R1 R6 idle ready", ready, 1'b1);
    end
  endtask

  task automatic run_stream(input int n, input logic [1:0] sel, input bit shp);
    int d;
    d = 1 << sel;
    @(negedge clk); #1;
    div_sel = sel; shape_en = shp; valid = 1'b1; wl_in = wl[0]; wr_in = wr[0];
    for (int i = 0; i <= n; i++) begin
      bit h;
      logic [31:0] el, er;
      h  = (i == n) || hole[i];
      el = h ? SILENCE : wl[i];
      er = h ? SILENCE : wr[i];
      for (int k = 0; k < 32; k++) begin
        for (int p = 0; p < d; p++) begin
          logic cut, ec;
          int nx;
          @(posedge clk); #1;
          cut = shp && (d > 1) && (p == d-1);
          ec  = (d == 1) ? 1'b0 : (p >= d/2);
          check("R2 R3 R10 left data", dl, play_bit(el, k) && !cut);
          check("R2 R3 R10 right data", dr, play_bit(er, k) && !cut);
          check("R4 R9 clock", dclk, ec);
          check("R6 ready", ready, (k == 31) && (p == d-1));
          check("R7 underrun", uflow, h);
          @(negedge clk); #1;
          if (d == 1) check("R5 clock high phase", dclk, 1'b1);
          // R9: scramble configuration inputs while streaming
          div_sel  = 2'($urandom);
          shape_en = 1'($urandom);
          if (k == 31 && p == d-1) begin
            nx = i + 1;
            valid = (nx < n) && !hole[nx];
            if (valid) begin wl_in = wl[nx]; wr_in = wr[nx]; end
            else begin wl_in = 32'($urandom); wr_in = 32'($urandom); end
          end
        end
      end
    end
    valid = 1'b0;
    idle_checks(4);
  endtask

  task automatic fill_random(input int n);
    for (int i = 0; i < 8; i++) begin
      wl[i] = 32'($urandom); wr[i] = 32'($urandom); hole[i] = 1'b0;
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) begin
      @(posedge clk); #1;
      check("R1 reset clock", dclk, 1'b0);
      check("R1 reset data", dl | dr, 1'b0);
      check("R1 reset underrun", uflow, 1'b0);
      check("R1 reset ready", ready, 1'b1);
    end
    @(negedge clk); rst_n = 1'b1;
    idle_checks(2);

    fill_random(3); run_stream(3, 2'd3, 1'b0);
    fill_random(4); hole[2] = 1'b1; run_stream(4, 2'd2, 1'b0);
    fill_random(3); run_stream(3, 2'd1, 1'b1);
    fill_random(4); hole[1] = 1'b1; run_stream(4, 2'd0, 1'b1);
    fill_random(3);
    wl[0] = 32'hFFFF_FFFF; wr[0] = 32'h0000_0000;
    wl[1] = 32'h8001_7FFE; wr[1] = 32'h0102_0408;
    wl[2] = 32'h0000_0000; wr[2] = 32'hFFFF_FFFF;
    run_stream(3, 2'd3, 1'b1);
    fill_random(5); hole[3] = 1'b1; run_stream(5, 2'd2, 1'b1);
    fill_random(2); run_stream(2, 2'd0, 1'b0);

    $display("CHECKS %0d ERRORS %0d", nchecks, nerr);
    $finish;
  end

  initial begin
    #(200000 * 5);
    nerr++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("CHECKS %0d ERRORS %0d", nchecks, nerr);
    $finish;
  end
endmodule